// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flag Controller

This block holds a group of sticky status flags. Event sources set them with single-cycle pulses. Software clears a flag in two steps. First it reads the status register while the flag is set, which arms that flag. Then it writes a zero to that flag's bit position, which clears it. A hardware set pulse always wins over a clear. A new set pulse after the read also cancels a pending clear, so software has to read the flag again.

While a debug break is active, the break-clear-enable bit decides whether software accesses count. This bit sits in a one-bit register inside the block, loaded through a configuration strobe, and it resets to 0. With the bit at 0, reads and writes made during the break do nothing. An armed flag stays armed through the break, and a write of zero after the break completes its clear. With the bit at 1, accesses during the break work as they do outside it, and a flag cleared during the break stays cleared afterwards.

Top module: `brkflag_ctrl`

## Requirements
- R1: After reset every flag reads 0, no flag is armed, and the break-clear-enable register reads 0.
- R2: A set pulse on bit i makes flag i read 1 from the following cycle, whether or not a break is active.
- R3: Outside a break, a read strobe while flag i is 1 arms it. A later write strobe with data bit i = 0 clears flag i on the next cycle.
- R4: A write of 0 to a flag that was not armed leaves it unchanged. A write of 1 never changes a flag and does not cancel an arming.
- R5: When a set pulse and a clearing write hit the same flag in one cycle, the flag stays 1.
- R6: A set pulse on an armed flag cancels the arming, so a following write of 0 leaves the flag at 1.
- R7: With the enable register at 0 and a break active, read and write strobes change neither the flags nor their armed state.
- R8: A flag armed before a protected break stays armed through it. A write of 0 after the break ends clears the flag.
- R9: Writing the configuration strobe loads the enable register from the config data. With it at 1, the two-step clear works during a break, and the cleared flag stays 0 once the break ends.
- R10: Each data bit acts only on its own flag, so one write can clear one armed flag while another armed flag, written with 1, keeps its value and its arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_pulse | input | NUM_FLAGS | Per-flag hardware set pulses |
| rd_stb | input | 1 | Status register read strobe |
| wr_stb | input | 1 | Status register write strobe |
| wr_data | input | NUM_FLAGS | Write data, one bit per flag |
| brk_active | input | 1 | Debug break state is active |
| cfg_we | input | 1 | Load strobe for the break-clear-enable register |
| cfg_din | input | 1 | Value loaded into the break-clear-enable register |
| clr_en_q | output | 1 | Current break-clear-enable register value |
| flags | output | NUM_FLAGS | Current flag states |

## Verification
The flags are driven through four patterns, and each one separates two cases.
- Write-only sequences (no read before the write) tell a real clear apart from a write that was never armed.
- Read-then-write sequences with a set pulse placed either in the same cycle as the write or between the read and the write tell set priority apart from cancellation of the arming.
- Accesses inside and outside a break with the enable register at 0 tell a blocked arming apart from an arming that was kept across the break.
- The same two-step sequence inside a break with the enable register at 1 shows that the enable really opens access, and that the clear persists after the break ends.

// File: rtl/brkflag_pkg.sv
package brkflag_pkg;

   // Bus access after the break gate has qualified it.
   typedef struct packed {
      logic rd;
      logic wr;
   } bus_req_t;

   localparam int unsigned MAX_FLAGS = 32;

endpackage

// File: rtl/brkflag_gate.sv
module brkflag_gate
   import brkflag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_we,
   input  logic     cfg_din,
   input  logic     brk_active,
   input  logic     rd_stb,
   input  logic     wr_stb,
   output logic     en_q,
   output bus_req_t req_ok
);

   logic access_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (cfg_we) en_q <= cfg_din;
   end

   assign access_ok  = !brk_active || en_q;
   assign req_ok.rd  = rd_stb && access_ok;
   assign req_ok.wr  = wr_stb && access_ok;

   // R9: configuration strobe loads the enable register
   a_r9_en_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (en_q == $past(cfg_din)));

   // R7: a locked break suppresses every qualified strobe
   a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_active && !en_q) |-> (!req_ok.rd && !req_ok.wr));

endmodule

// File: rtl/brkflag_cell.sv
module brkflag_cell #(
   parameter bit CANCEL_ON_SET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_ok,
   input  logic wr_ok,
   input  logic wbit,
   output logic flag_o
);

   logic armed;
   logic keep_arm;

   generate
      if (CANCEL_ON_SET) begin : g_cancel
         assign keep_arm = 1'b0;
      end else begin : g_keep
         assign keep_arm = armed;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         armed  <= 1'b0;
      end else if (set_i) begin
         flag_o <= 1'b1;
         armed  <= keep_arm;
      end else if (wr_ok && armed && !wbit) begin
         flag_o <= 1'b0;
         armed  <= 1'b0;
      end else if (rd_ok && flag_o) begin
         armed  <= 1'b1;
      end
   end

   // R5: set wins over any clear in the same cycle
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   // R4: a flag only falls after a write of 0 was accepted
   a_r4_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(wr_ok && !wbit));

   // R3: a flag only falls if it had been armed
   a_r3_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(armed));

endmodule

// File: rtl/brkflag_ctrl.sv
module brkflag_ctrl
   import brkflag_pkg::*;
#(
   parameter int unsigned NUM_FLAGS     = 4,
   parameter bit          CANCEL_ON_SET = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_pulse,
   input  logic                 rd_stb,
   input  logic                 wr_stb,
   input  logic [NUM_FLAGS-1:0] wr_data,
   input  logic                 brk_active,
   input  logic                 cfg_we,
   input  logic                 cfg_din,
   output logic                 clr_en_q,
   output logic [NUM_FLAGS-1:0] flags
);

   localparam int unsigned LAST = NUM_FLAGS - 1;

   generate
      if (NUM_FLAGS < 1 || NUM_FLAGS > MAX_FLAGS) begin : g_bad_width
         $error("brkflag_ctrl: NUM_FLAGS out of range");
      end
   endgenerate

   bus_req_t req_ok;

   brkflag_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_din    (cfg_din),
      .brk_active (brk_active),
      .rd_stb     (rd_stb),
      .wr_stb     (wr_stb),
      .en_q       (clr_en_q),
      .req_ok     (req_ok)
   );

   generate
      for (genvar i = 0; i <= LAST; i++) begin : g_cell
         brkflag_cell #(.CANCEL_ON_SET(CANCEL_ON_SET)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_pulse[i]),
            .rd_ok  (req_ok.rd),
            .wr_ok  (req_ok.wr),
            .wbit   (wr_data[i]),
            .flag_o (flags[i])
         );
      end
   endgenerate

   // R7: locked break with no set pulse keeps every flag stable
   a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_active && !clr_en_q && set_pulse == '0) |=> $stable(flags));

   // R2: a set pulse raises its flag on the next cycle
   a_r2_set_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pulse[0]) |=> flags[0]);

endmodule

// File: tb/brkflag_ctrl_test.sv
`timescale 1ns/1ps
module brkflag_ctrl_test;

   localparam int N    = 4;
   localparam int NVEC = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] set_pulse = '0;
   logic         rd_stb = 1'b0;
   logic         wr_stb = 1'b0;
   logic [N-1:0] wr_data = '0;
   logic         brk_active = 1'b0;
   logic         cfg_we = 1'b0;
   logic         cfg_din = 1'b0;
   logic         clr_en_q;
   logic [N-1:0] flags;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   brkflag_ctrl #(.NUM_FLAGS(N)) uut (
      .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .wr_data(wr_data), .brk_active(brk_active),
      .cfg_we(cfg_we), .cfg_din(cfg_din), .clr_en_q(clr_en_q), .flags(flags)
   );

   // {set[3:0], rd, wr, wdata[3:0], brk, expected flags[3:0]}
   localparam logic [14:0] VEC [NVEC] = '{
      {4'b0001, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b0001}, // R2 set bit0
      {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b0001}, // R4 unarmed write 0
      {4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0001}, // R3 arm bit0
      {4'b0000, 1'b0, 1'b1, 4'b1111, 1'b0, 4'b0001}, // R4 write 1
      {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b0000}, // R3 clear
      {4'b0110, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b0110}, // R2 set bits 1,2
      {4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0110}, // R3 arm 1,2
      {4'b0010, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b0010}, // R5 bit1 set wins, bit2 clears
      {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b0010}, // R6 set disarmed bit1
      {4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0010}, // R6 re-arm bit1
      {4'b0010, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b0010}, // R6 set cancels arming
      {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b0010}, // R6 write has no effect
      {4'b0000, 1'b1, 1'b0, 4'b0000, 1'b1, 4'b0010}, // R7 read in locked break
      {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b0010}, // R7 that read did not arm
      {4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0, 4'b0010}, // R8 arm before break
      {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b1, 4'b0010}, // R8 write blocked in break
      {4'b0000, 1'b0, 1'b0, 4'b0000, 1'b1, 4'b0010}, // R8 break idle
      {4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b0000}, // R8 clear after break
      {4'b1000, 1'b0, 1'b0, 4'b0000, 1'b1, 4'b1000}, // R2 set during break
      {4'b0000, 1'b0, 1'b1, 4'b0111, 1'b0, 4'b1000}  // R4 unarmed bit3 write 0
   };

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic drive(input logic [N-1:0] s, input logic r, input logic w,
                        input logic [N-1:0] d, input logic b);
      set_pulse = s; rd_stb = r; wr_stb = w; wr_data = d; brk_active = b;
      @(negedge clk);
      set_pulse = '0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 flags", flags, '0);
      check("R1 enable", {3'b000, clr_en_q}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NVEC; k++) begin
         drive(VEC[k][14:11], VEC[k][10], VEC[k][9], VEC[k][8:5], VEC[k][4]);
         check($sformatf("vector %0d", k), flags, VEC[k][3:0]);
      end
      brk_active = 1'b0;

      // R10: clear bit3, keep armed bit0 via data 1
      drive(4'b0001, 1'b0, 1'b0, 4'b0000, 1'b0);
      drive(4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0);
      drive(4'b0000, 1'b0, 1'b1, 4'b0001, 1'b0);
      check("R10 one bit cleared", flags, 4'b0001);
      drive(4'b0000, 1'b0, 1'b1, 4'b1110, 1'b0);
      check("R10 other stayed armed", flags, 4'b0000);

      // R9: enable clearing during break
      cfg_we = 1'b1; cfg_din = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; cfg_din = 1'b0;
      check("R9 enable loaded", {3'b000, clr_en_q}, 4'b0001);
      drive(4'b0100, 1'b0, 1'b0, 4'b0000, 1'b0);
      drive(4'b0000, 1'b1, 1'b0, 4'b0000, 1'b1);
      drive(4'b0000, 1'b0, 1'b1, 4'b0000, 1'b1);
      check("R9 cleared in break", flags, 4'b0000);
      drive(4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0);
      check("R9 stays cleared", flags, 4'b0000);

      // R1: reset again clears flags and enable
      drive(4'b1010, 1'b0, 1'b0, 4'b0000, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 flags after reset", flags, '0);
      check("R1 enable after reset", {3'b000, clr_en_q}, 4'b0000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule